// File: doc/BRIEF.md
# Half-Group Memory Request Coalescer

This block takes one batch of memory requests from a group of sixteen threads and folds it into the fewest aligned memory transactions that a fixed, iterative selection procedure allows. Each batch carries a byte address per thread, a per-thread active bit and a single element-size code that applies to the whole batch. The block repeatedly picks the lowest-numbered thread still waiting, forms the aligned segment around that thread's address, gathers every waiting thread whose address lies in that segment, trims the segment to the smaller aligned piece that is actually touched, and offers the result downstream.

Each transaction leaves with its aligned base address, its length in bytes and a mask of the threads it serves, under a valid/ready handshake. When no thread remains waiting the block pulses a completion flag and reports how many transactions the batch needed. A new batch is taken only while the block is idle; the memory, return-data steering and caching lie outside it.

Top module: `hw_coalescer`

## Requirements
- R1: `in_ready` is high exactly when no batch is in progress; a batch is captured on a clock edge where `in_valid` and `in_ready` are both high, and `in_valid` while busy leaves the current batch and its transactions unchanged.
- R2: Every transaction serves the lowest-numbered thread that was still waiting when it was formed, and transactions leave in increasing order of that thread number.
- R3: The segment width follows the size code `in_esz`: code 0 (8-bit elements) gives 32 bytes, code 1 (16-bit) gives 64 bytes, codes 2, 3 and 4 (32-, 64- and 128-bit) and any higher code give 128 bytes; every base address is a multiple of the transaction length.
- R4: A 128-byte segment whose served addresses all lie in its lower 64 bytes, or all in its upper 64 bytes, is issued as a 64-byte transaction covering only that half.
- R5: A 64-byte segment or trimmed half whose served addresses lie in one 32-byte half is issued as a 32-byte transaction over that half, so a 128-byte segment can end as 32 bytes.
- R6: The thread mask of a transaction holds every waiting thread whose address shares the chosen segment, and no other thread; each of these threads is then no longer waiting.
- R7: Transactions continue until every active thread of the batch has been served exactly once.
- R8: One cycle after the last transfer, `done` is high for one cycle and `done_count` equals the number of transactions; a batch with no active thread raises `done` one cycle after capture with a count of zero and issues nothing.
- R9: At most one transfer happens per cycle, only when `tx_ready` is high; while `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_base`, `tx_bytes` and `tx_mask` hold their values.
- R10: After reset `in_ready` is high and `tx_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A batch is offered |
| in_ready | output | 1 | Block idle, batch can be captured |
| in_addr | input | NT*AW | Byte address of thread t in bits [t*AW +: AW] |
| in_active | input | NT | Per-thread request bit |
| in_esz | input | 3 | Element size code shared by the batch |
| tx_valid | output | 1 | A transaction is offered |
| tx_ready | input | 1 | Downstream takes the transaction |
| tx_base | output | AW | Aligned base byte address of the transaction |
| tx_bytes | output | 8 | Transaction length: 32, 64 or 128 |
| tx_mask | output | NT | Threads served by the transaction |
| done | output | 1 | One-cycle pulse when the batch is fully served |
| done_count | output | CW | Transactions used by the finished batch |

## Verification
A wrong waiting-thread set shows up on the very next offered transaction: its mask either misses the lowest waiting thread, repeats a thread already served, or the batch runs one transaction too many or too few, which `done_count` exposes one cycle after the last transfer. A wrong trim decision appears at once as a base or length that differs from the expected segment piece, while the mask may still look right, so both fields are compared on every transfer. A stall that lets internal state move is visible in the cycle after `tx_ready` drops, as a changed transaction field.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // element size codes for a batch
  typedef enum logic [2:0] {
    ESZ_B8   = 3'd0,
    ESZ_B16  = 3'd1,
    ESZ_B32  = 3'd2,
    ESZ_B64  = 3'd3,
    ESZ_B128 = 3'd4
  } esz_e;

  localparam int unsigned CHUNK_BYTES = 32;
  localparam int unsigned NUM_CHUNKS  = 4;

  typedef struct packed {
    logic [7:0] bytes;
    logic [1:0] first_chunk;
  } trim_t;

  // segment width in bytes for a size code
  function automatic logic [7:0] seg_bytes(input logic [2:0] code);
    logic [7:0] r;
    case (code)
      ESZ_B8:  r = 8'd32;
      ESZ_B16: r = 8'd64;
      default: r = 8'd128;
    endcase
    return r;
  endfunction

  // which 32-byte chunks of the segment may be non-zero
  function automatic logic [1:0] chunk_sel_mask(input logic [7:0] sz);
    logic [1:0] r;
    if (sz == 8'd128)      r = 2'b11;
    else if (sz == 8'd64)  r = 2'b01;
    else                   r = 2'b00;
    return r;
  endfunction

  // trim a segment to its touched half, then the touched quarter
  function automatic trim_t trim_seg(input logic [7:0] sz, input logic [3:0] used);
    trim_t      r;
    logic [1:0] halves;
    r.bytes       = sz;
    r.first_chunk = 2'd0;
    halves        = used[1:0];
    if (sz == 8'd128) begin
      if (used[3:2] == 2'b00) begin
        r.bytes = 8'd64;
        halves  = used[1:0];
      end else if (used[1:0] == 2'b00) begin
        r.bytes       = 8'd64;
        r.first_chunk = 2'd2;
        halves        = used[3:2];
      end
    end
    if (r.bytes == 8'd64) begin
      if (halves == 2'b01) begin
        r.bytes = 8'd32;
      end else if (halves == 2'b10) begin
        r.bytes       = 8'd32;
        r.first_chunk = r.first_chunk + 2'd1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/coal_seed_pick.sv
module coal_seed_pick #(
  parameter int NT = 16,
  localparam int IW = $clog2(NT)
) (
  input  logic [NT-1:0] pending,
  output logic [IW-1:0] seed_idx,
  output logic [NT-1:0] seed_oh,
  output logic          any_pending
);

  // index by priority scan from the top, one-hot by two's complement
  always_comb begin
    seed_idx = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (pending[t]) seed_idx = IW'(t);
    end
  end

  assign seed_oh     = pending & (~pending + NT'(1));
  assign any_pending = |pending;

endmodule

// File: rtl/coal_seg_build.sv
module coal_seg_build
  import coal_pkg::*;
#(
  parameter int NT = 16,
  parameter int AW = 32,
  localparam int IW = $clog2(NT)
) (
  input  logic [NT*AW-1:0] addr_flat,
  input  logic [NT-1:0]    pending,
  input  logic [IW-1:0]    seed_idx,
  input  logic [2:0]       esz,
  output logic [AW-1:0]    tx_base,
  output logic [7:0]       tx_bytes,
  output logic [NT-1:0]    tx_mask
);

  logic [7:0]    seg_sz;
  logic [AW-1:0] off_msk;
  logic [AW-1:0] seed_addr;
  logic [AW-1:0] seg_base;
  logic [1:0]    csel;
  logic [3:0]    used_v [NT];
  logic [3:0]    used;
  trim_t         trim;

  assign seg_sz    = seg_bytes(esz);
  assign off_msk   = AW'(seg_sz) - AW'(1);
  assign seed_addr = addr_flat[seed_idx*AW +: AW];
  assign seg_base  = seed_addr & ~off_msk;
  assign csel      = chunk_sel_mask(seg_sz);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [AW-1:0] a;
    logic [1:0]    chunk;
    assign a          = addr_flat[t*AW +: AW];
    assign tx_mask[t] = pending[t] && ((a & ~off_msk) == seg_base);
    assign chunk      = a[6:5] & csel;
    assign used_v[t]  = tx_mask[t] ? (4'b0001 << chunk) : 4'b0000;
  end

  always_comb begin
    used = '0;
    for (int t = 0; t < NT; t++) used = used | used_v[t];
  end

  assign trim     = trim_seg(seg_sz, used);
  assign tx_bytes = trim.bytes;
  assign tx_base  = seg_base | AW'({trim.first_chunk, 5'b00000});

endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
  import coal_pkg::*;
#(
  parameter int NT = 16,
  parameter int AW = 32,
  localparam int IW = $clog2(NT),
  localparam int CW = $clog2(NT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NT*AW-1:0] in_addr,
  input  logic [NT-1:0]    in_active,
  input  logic [2:0]       in_esz,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [AW-1:0]    tx_base,
  output logic [7:0]       tx_bytes,
  output logic [NT-1:0]    tx_mask,
  output logic             done,
  output logic [CW-1:0]    done_count
);

  logic [NT*AW-1:0] addr_q;
  logic [NT-1:0]    pending_q;
  logic [2:0]       esz_q;
  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic             done_q;
  logic [CW-1:0]    done_cnt_q;

  // named internal events
  logic [IW-1:0] seed_idx;
  logic [NT-1:0] seed_oh;
  logic          any_pending;
  logic          accept;
  logic          fire;
  logic [NT-1:0] pend_next;
  logic          last_fire;

  coal_seed_pick #(.NT(NT)) u_seed (
    .pending     (pending_q),
    .seed_idx    (seed_idx),
    .seed_oh     (seed_oh),
    .any_pending (any_pending)
  );

  coal_seg_build #(.NT(NT), .AW(AW)) u_seg (
    .addr_flat (addr_q),
    .pending   (pending_q),
    .seed_idx  (seed_idx),
    .esz       (esz_q),
    .tx_base   (tx_base),
    .tx_bytes  (tx_bytes),
    .tx_mask   (tx_mask)
  );

  assign in_ready   = !busy_q;
  assign accept     = in_valid && in_ready;
  assign tx_valid   = busy_q && any_pending;
  assign fire       = tx_valid && tx_ready;
  assign pend_next  = pending_q & ~tx_mask;
  assign last_fire  = fire && (pend_next == '0);
  assign done       = done_q;
  assign done_count = done_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      pending_q  <= '0;
      esz_q      <= '0;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
      done_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q    <= in_addr;
        esz_q     <= in_esz;
        pending_q <= in_active;
        cnt_q     <= '0;
        busy_q    <= |in_active;
        if (in_active == '0) begin
          done_q     <= 1'b1;
          done_cnt_q <= '0;
        end
      end else if (fire) begin
        pending_q <= pend_next;
        cnt_q     <= cnt_q + CW'(1);
        if (last_fire) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          done_cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // R9: offered transaction is frozen under back-pressure
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) && $stable(tx_bytes) && $stable(tx_mask));

  // R2: scan index and one-hot seed agree, and the seed is served
  a_r2_seed_served: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> seed_oh[seed_idx] && ((tx_mask & seed_oh) != '0));

  // R6: only waiting threads are served
  a_r6_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_mask & ~pending_q) == '0));

  // R3: base aligned to the transaction length
  a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_base & (AW'(tx_bytes) - AW'(1))) == '0));

  // R5: only the three legal lengths appear
  a_r5_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($onehot(tx_bytes) && (tx_bytes[4:0] == 5'd0)));

  // R7: every transfer strictly shrinks the waiting set
  a_r7_progress: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($countones(pending_q) < $past($countones(pending_q))));

  // R1: no capture while a transaction is offered
  a_r1_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !in_ready);

  // R8: completion never overlaps an offered transaction, count bounded
  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid && (done_count <= CW'(NT)));

endmodule

// File: tb/hw_coalescer_bench.sv
module hw_coalescer_bench;
  localparam int NT = 16;
  localparam int AW = 32;
  localparam int CW = $clog2(NT + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [NT*AW-1:0] in_addr = '0;
  logic [NT-1:0]    in_active = '0;
  logic [2:0]       in_esz = '0;
  logic             tx_valid;
  logic             tx_ready = 1'b0;
  logic [AW-1:0]    tx_base;
  logic [7:0]       tx_bytes;
  logic [NT-1:0]    tx_mask;
  logic             done;
  logic [CW-1:0]    done_count;

  hw_coalescer #(.NT(NT), .AW(AW)) u_hw_coalescer (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] ta [NT];
  logic [31:0] eb [NT];
  int          ez [NT];
  logic [15:0] em [NT];
  int          en;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // reference model written from the requirements (min/max of offsets)
  task automatic build_exp(input logic [2:0] code, input logic [15:0] act);
    logic [15:0] pend = act;
    en = 0;
    while (pend != 0) begin
      int s = 0, sz, lo = 1000, hi = -1;
      logic [31:0] base, b;
      logic [15:0] m = 0;
      while (!pend[s]) s++;
      sz = (code == 0) ? 32 : (code == 1) ? 64 : 128;
      base = ta[s] & ~(32'(sz) - 1);
      for (int t = 0; t < NT; t++) begin
        if (pend[t] && ((ta[t] & ~(32'(sz) - 1)) == base)) begin
          int off = int'(ta[t] - base);
          m[t] = 1'b1;
          if (off < lo) lo = off;
          if (off > hi) hi = off;
        end
      end
      b = base;
      if (sz == 128) begin
        if (hi < 64) sz = 64;
        else if (lo >= 64) begin sz = 64; b = base + 64; lo -= 64; hi -= 64; end
      end
      if (sz == 64) begin
        if (hi < 32) sz = 32;
        else if (lo >= 32) begin sz = 32; b = b + 32; end
      end
      eb[en] = b; ez[en] = sz; em[en] = m; en++;
      pend = pend & ~m;
    end
  endtask

  task automatic send(input logic [2:0] code, input logic [15:0] act);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready before capture", in_ready, 1);
    for (int t = 0; t < NT; t++) in_addr[t*AW +: AW] = ta[t];
    in_active = act;
    in_esz    = code;
    in_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // collects transfers; stall inserts back-pressure, poke offers junk while busy
  task automatic collect(input bit stall, input bit poke, input string req);
    int got = 0, guard = 0;
    bit fin = 0, pstall = 0;
    logic [31:0] sb; logic [7:0] sz; logic [15:0] sm;
    // first sample is this negedge (already at it after send)
    while (!fin && guard < 400) begin
      bit rdy;
      if (guard > 0) @(negedge clk);
      guard++;
      if (pstall) begin
        chk(tx_valid == 1'b1, "R9", "valid held", tx_valid, 1);
        chk(tx_base == sb && tx_bytes == sz && tx_mask == sm, "R9", "fields held", tx_base, sb);
        pstall = 0;
      end
      if (done) begin
        chk(tx_valid == 1'b0, "R8", "no tx at done", tx_valid, 0);
        chk(got == en, "R7", "transfers seen", got, en);
        chk(int'(done_count) == en, "R8", "done_count", done_count, en);
        fin = 1;
        in_valid = 1'b0;
        tx_ready = 1'b0;
      end else begin
        if (poke) begin
          chk(in_ready == 1'b0, "R1", "in_ready while busy", in_ready, 0);
          in_valid  = 1'b1;
          in_active = 16'hFFFF;
          in_esz    = 3'd0;
        end
        rdy = stall ? ((guard % 3) != 0) : 1'b1;
        tx_ready = rdy;
        if (tx_valid) begin
          if (rdy) begin
            if (got < en) begin
              chk(tx_base == eb[got], req, "tx_base", tx_base, eb[got]);
              chk(int'(tx_bytes) == ez[got], req, "tx_bytes", tx_bytes, ez[got]);
              chk(tx_mask == em[got], "R6", "tx_mask", tx_mask, em[got]);
            end else begin
              chk(1'b0, "R7", "extra transfer", got, en);
            end
            got++;
          end else begin
            pstall = 1; sb = tx_base; sz = tx_bytes; sm = tx_mask;
          end
        end
      end
    end
    chk(fin, "R8", "done seen", fin, 1);
  endtask

  task automatic run(input logic [2:0] code, input logic [15:0] act,
                     input bit stall, input bit poke, input string req);
    build_exp(code, act);
    send(code, act);
    collect(stall, poke, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", "in_ready", in_ready, 1);
    chk(tx_valid == 1'b0, "R10", "tx_valid", tx_valid, 0);
    chk(done == 1'b0, "R10", "done", done, 0);
  endtask

  task automatic t_words_lower_half(); // R4: 64 bytes in low half of 128
    for (int t = 0; t < NT; t++) ta[t] = 32'h1000 + 32'(4 * t);
    run(3'd2, 16'hFFFF, 0, 0, "R4");
    chk(en == 1 && ez[0] == 64, "R4", "model one 64B tx", ez[0], 64);
  endtask

  task automatic t_bytes(); // R3: byte elements, 32B segment
    for (int t = 0; t < NT; t++) ta[t] = 32'h2007 + 32'(t);
    run(3'd0, 16'hFFFF, 0, 0, "R3");
  endtask

  task automatic t_half_shrink(); // R5: 16-bit, only low 32B of 64B used
    for (int t = 0; t < NT; t++) ta[t] = 32'h3000 + 32'(2 * t);
    run(3'd1, 16'hFFFF, 0, 0, "R5");
    chk(ez[0] == 32, "R5", "model 32B", ez[0], 32);
  endtask

  task automatic t_stride(); // R5 chained, R2 ordering: one tx per thread
    for (int t = 0; t < NT; t++) ta[t] = 32'h10000 + 32'(128 * (NT - 1 - t)) + 32'h60;
    run(3'd2, 16'hFFFF, 0, 0, "R2");
  endtask

  task automatic t_upper(); // R4 upper half, then R5 upper quarter
    for (int t = 0; t < NT; t++) ta[t] = 32'h4040 + 32'(4 * t);
    run(3'd3, 16'hFFFF, 0, 0, "R4");
    for (int t = 0; t < NT; t++) ta[t] = 32'h5060 + 32'(4 * (t % 8));
    run(3'd2, 16'hFFFF, 0, 0, "R5");
  endtask

  task automatic t_scatter(); // R6/R7: sparse mask, scattered addresses
    for (int t = 0; t < NT; t++) ta[t] = 32'h8000 + 32'(((t * 7) % 16) * 24);
    run(3'd2, 16'hA5F3, 0, 0, "R6");
    for (int t = 0; t < NT; t++) ta[t] = 32'h9000 + 32'(16 * t);
    run(3'd4, 16'hFFFF, 0, 0, "R3");
    run(3'd7, 16'h8001, 0, 0, "R3");
  endtask

  task automatic t_empty(); // R8: no active thread
    en = 0;
    send(3'd2, 16'h0000);
    chk(done == 1'b1, "R8", "done on empty", done, 1);
    chk(done_count == '0, "R8", "count on empty", done_count, 0);
    chk(tx_valid == 1'b0, "R8", "no tx on empty", tx_valid, 0);
  endtask

  task automatic t_stall_poke(); // R9 back-pressure, R1 input ignored while busy
    for (int t = 0; t < NT; t++) ta[t] = 32'h20000 + 32'(40 * t);
    run(3'd2, 16'hFFFF, 1, 0, "R9");
    run(3'd1, 16'h7FFE, 0, 1, "R1");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_words_lower_half();
    t_bytes();
    t_half_shrink();
    t_stride();
    t_upper();
    t_scatter();
    t_empty();
    t_stall_poke();
    t_reset();
    finish_run();
  end

endmodule